// File: doc/BRIEF.md
# Timer Capture/Compare Channel Bank

This block is a set of timer channels built around one shared free-running counter. The counter is a plain incrementer. It advances by one on every clock while its enable input is high. Each channel owns a single register that serves one of two uses, and a per-channel mode bit picks the use.

In capture mode, a synchronized edge detector watches the channel's input pin. On the selected transition it copies the counter into the register. In compare mode, software loads the register through the write port. When the counter reaches that value, the channel drives a programmed action on its output pin.

Every capture or compare event raises a sticky per-channel flag, and software clears a flag by writing 1 to it. Software writes to a channel in capture mode are dropped without any indication, so the register only ever holds captured counter values in that mode. The read port is synchronous and returns data one clock after the address is presented.

Top module: `tmr_chan_bank`

## Requirements
- R1: After reset the counter output reads 0. On each rising clock edge with `cnt_en` high it increases by one and wraps from 0xFFFF to 0x0000. With `cnt_en` low it holds its value.
- R2: In capture mode (`mode_cmp` bit = 0), a qualifying edge on the channel's pin loads the counter into the channel register. Take the clock edge at which the pin first differs as edge k. The loaded value is the counter value present between clock edges k+1 and k+2.
- R3: The 2-bit edge select of channel i is `edge_sel[2i+1:2i]`. The codes are 00 = never capture, 01 = rising edge only, 10 = falling edge only, 11 = both edges. A transition that the code does not select leaves both the register and the flag unchanged.
- R4: In compare mode (`mode_cmp` bit = 1), a write with `wr_addr` = i loads `wr_data` into channel register i at that clock edge.
- R5: A write to a channel in capture mode leaves its register unchanged. This also holds when a capture lands on the same clock edge as the write, in which case the captured counter value is kept.
- R6: All channel registers are 0x0000 after reset. `rd_data` shows the register addressed by `rd_addr` (0..NCH-1) one clock after `rd_addr` is sampled. Address NCH returns the flags in bits NCH-1:0.
- R7: A capture or a compare match sets flag i, and the flag stays set. A write to address NCH with `wr_data` bit i = 1 clears flag i and leaves the other flags as they are. If a set and a clear arrive on the same edge, the set wins.
- R8: A compare match event occurs on the first clock in which the counter equals the register of a compare-mode channel. On the next clock edge the output applies the action in `act_sel[2i+1:2i]`: 00 = no change, 01 = toggle, 10 = drive 0, 11 = drive 1.
- R9: After reset all flags and all output pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter advance enable |
| mode_cmp | input | NCH | Per-channel mode bit: 1 = compare, 0 = capture |
| edge_sel | input | 2*NCH | Per-channel capture edge select |
| act_sel | input | 2*NCH | Per-channel compare output action |
| cap_in | input | NCH | Capture input pins (asynchronous) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address: channel index, or NCH for flag clear |
| wr_data | input | CW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | CW | Registered read data |
| cnt_val | output | CW | Current counter value |
| flags | output | NCH | Sticky event flags |
| cmp_out | output | NCH | Compare output pins |

## Verification
A fault in the input synchronizer or edge logic shows up in two ways. Either a wrong or missing value appears in the register on the third edge after the pin moves, or a flag rises on an edge that the select code should ignore. A wrong write gate shows within one read as a register that took data in capture mode. A fault in the match or action logic shows on `cmp_out` and `flags` exactly one clock after the counter reaches the programmed value. The bench therefore samples each of those cycles directly, not merely the eventual result.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } out_act_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt == $past(cnt) + 1'b1); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt)); // R1
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       evt
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] shr;
  logic             cur, prv;

  always_ff @(posedge clk) begin
    if (rst) shr <= '0;
    else     shr <= {shr[DEPTH-2:0], pin};
  end

  assign cur = shr[SYNC_STAGES-1];
  assign prv = shr[SYNC_STAGES];

  always_comb begin
    unique case (edge_sel_e'(sel))
      EDGE_RISE: evt = cur & ~prv;
      EDGE_FALL: evt = ~cur & prv;
      EDGE_ANY:  evt = cur ^ prv;
      default:   evt = 1'b0;
    endcase
  end

  AST_OFF_NO_EVT: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |-> !evt); // R3
  AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    evt |-> (cur != prv)); // R3
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_mode,
  input  logic [CW-1:0] cnt,
  input  logic          cap_evt,
  input  logic          wr_hit,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    act,
  input  logic          flag_clr,
  output logic [CW-1:0] val,
  output logic          flag,
  output logic          pin_out
);
  logic match_now, match_q, hit, cap;

  assign match_now = (val == cnt);
  assign hit       = cmp_mode & match_now & ~match_q;
  assign cap       = ~cmp_mode & cap_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      val     <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match_now;
      if (cap)                   val <= cnt;
      else if (cmp_mode && wr_hit) val <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            flag <= 1'b0;
    else if (cap | hit) flag <= 1'b1;
    else if (flag_clr)  flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_out <= 1'b0;
    else if (hit) begin
      unique case (out_act_e'(act))
        ACT_TOGGLE: pin_out <= ~pin_out;
        ACT_CLEAR:  pin_out <= 1'b0;
        ACT_SET:    pin_out <= 1'b1;
        default:    pin_out <= pin_out;
      endcase
    end
  end

  AST_CAP_LOADS: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && !cmp_mode) |=> val == $past(cnt)); // R2
  AST_CAP_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!cmp_mode && !cap_evt) |=> $stable(val)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag); // R7
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(pin_out)); // R8
endmodule

// File: rtl/tmr_chan_bank.sv
module tmr_chan_bank
  import tmr_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [NCH-1:0]   mode_cmp,
  input  logic [2*NCH-1:0] edge_sel,
  input  logic [2*NCH-1:0] act_sel,
  input  logic [NCH-1:0]   cap_in,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CW-1:0]    rd_data,
  output logic [CW-1:0]    cnt_val,
  output logic [NCH-1:0]   flags,
  output logic [NCH-1:0]   cmp_out
);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(NCH);

  logic [CW-1:0] regs [NCH];
  logic [NCH-1:0] cap_evt;
  logic [CW-1:0] rd_next;

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .cnt(cnt_val)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .pin(cap_in[i]),
      .sel(edge_sel[2*i +: 2]), .evt(cap_evt[i])
    );
    tmr_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst(rst), .cmp_mode(mode_cmp[i]), .cnt(cnt_val),
      .cap_evt(cap_evt[i]),
      .wr_hit(wr_en && (wr_addr == AW'(i))),
      .wr_data(wr_data), .act(act_sel[2*i +: 2]),
      .flag_clr(wr_en && (wr_addr == FLAG_ADDR) && wr_data[i]),
      .val(regs[i]), .flag(flags[i]), .pin_out(cmp_out[i])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(i)) rd_next = regs[i];
    end
    if (rd_addr == FLAG_ADDR) begin
      for (int i = 0; i < NCH; i++) rd_next[i] = flags[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  initial begin
    AST_NCH_FITS: assert (NCH <= CW && SYNC_STAGES >= 2); // R7
  end
endmodule

// File: tb/tmr_chan_bank_test.sv
module tmr_chan_bank_test;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = $clog2(NCH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0;
  logic [NCH-1:0] mode_cmp = '0;
  logic [2*NCH-1:0] edge_sel = '0;
  logic [2*NCH-1:0] act_sel = '0;
  logic [NCH-1:0] cap_in = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data, cnt_val;
  logic [NCH-1:0] flags, cmp_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_chan_bank #(.NCH(NCH), .CW(CW)) uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode_cmp(mode_cmp),
    .edge_sel(edge_sel), .act_sel(act_sel), .cap_in(cap_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_val(cnt_val),
    .flags(flags), .cmp_out(cmp_out)
  );

  // table entry: {channel[3:0], write data[15:0], expected readback[15:0]}
  // mode_cmp = 4'b0011 while walking it
  localparam logic [35:0] VEC [8] = '{
    {4'd0, 16'h1234, 16'h1234},
    {4'd2, 16'hBEEF, 16'h0000},
    {4'd1, 16'hFFFF, 16'hFFFF},
    {4'd3, 16'h0001, 16'h0000},
    {4'd0, 16'hA5A5, 16'hA5A5},
    {4'd2, 16'h7777, 16'h0000},
    {4'd1, 16'h0100, 16'h0100},
    {4'd3, 16'hFFFF, 16'h0000}
  };

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic run_to(input logic [CW-1:0] t);
    cnt_en = 1'b1;
    while (cnt_val !== t) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v, c0, c1;
    step(3);
    rst = 1'b0;
    step(1);
    // reset state
    chk("R1 counter after reset", cnt_val, 16'h0);
    chk("R9 flags after reset", {12'h0, flags}, 16'h0);
    chk("R9 outputs after reset", {12'h0, cmp_out}, 16'h0);
    for (int i = 0; i < NCH; i++) begin
      rd(AW'(i), v);
      chk("R6 register reset value", v, 16'h0);
    end

    // counter step, hold, wrap
    cnt_en = 1'b1; step(10); cnt_en = 1'b0;
    chk("R1 counter advance", cnt_val, 16'd10);
    step(5);
    chk("R1 counter hold", cnt_val, 16'd10);
    cnt_en = 1'b1; step(65536); cnt_en = 1'b0;
    chk("R1 counter wrap", cnt_val, 16'd10);

    // table walk: compare-mode writes land, capture-mode writes drop
    mode_cmp = 4'b0011;
    for (int i = 0; i < 8; i++) begin
      wr(AW'(VEC[i][35:32]), VEC[i][31:16]);
      rd(AW'(VEC[i][35:32]), v);
      chk(mode_cmp[VEC[i][35:32]] ? "R4 compare write" : "R5 capture write dropped",
          v, VEC[i][15:0]);
    end

    // rising capture on channel 2
    edge_sel = 8'b00_01_00_00;
    c0 = cnt_val;
    cap_in[2] = 1'b1; step(3);
    rd(AW'(2), v);
    chk("R2 rising capture value", v, c0);
    chk("R7 flag set by capture", {15'h0, flags[2]}, 16'h1);
    // falling edge ignored with rising select
    cnt_en = 1'b1; step(7); cnt_en = 1'b0;
    cap_in[2] = 1'b0; step(4);
    rd(AW'(2), v);
    chk("R3 falling ignored on rise select", v, c0);
    // clear flag 2 only
    chk("R7 flag 2 still set", {15'h0, flags[2]}, 16'h1);
    wr(AW'(NCH), 16'h0004); step(1);
    chk("R7 flag 2 cleared", {15'h0, flags[2]}, 16'h0);
    // falling select
    edge_sel = 8'b00_10_00_00;
    cap_in[2] = 1'b1; step(4);
    rd(AW'(2), v);
    chk("R3 rising ignored on fall select", v, c0);
    c1 = cnt_val;
    cap_in[2] = 1'b0; step(4);
    rd(AW'(2), v);
    chk("R3 falling capture", v, c1);
    // off select
    wr(AW'(NCH), 16'h0004);
    edge_sel = 8'b00_00_00_00;
    cnt_en = 1'b1; step(3); cnt_en = 1'b0;
    cap_in[2] = 1'b1; step(4); cap_in[2] = 1'b0; step(4);
    rd(AW'(2), v);
    chk("R3 off select keeps register", v, c1);
    chk("R3 off select keeps flag", {15'h0, flags[2]}, 16'h0);

    // both edges on channel 3 with running counter, exact timing
    edge_sel = 8'b11_00_00_00;
    cnt_en = 1'b1;
    cap_in[3] = 1'b1;
    step(2);
    c0 = cnt_val;
    step(2);
    cnt_en = 1'b0;
    rd(AW'(3), v);
    chk("R2 capture timing with running counter", v, c0);
    cnt_en = 1'b1;
    cap_in[3] = 1'b0;
    step(2);
    c1 = cnt_val;
    step(2);
    cnt_en = 1'b0;
    rd(AW'(3), v);
    chk("R3 both-edge select falling capture", v, c1);

    // capture and write on the same edge
    edge_sel = 8'b11_01_00_00;
    cnt_en = 1'b1; step(5); cnt_en = 1'b0;
    c0 = cnt_val;
    cap_in[2] = 1'b1; step(2);
    wr(AW'(2), 16'h5555);
    step(1);
    rd(AW'(2), v);
    chk("R5 capture wins over write", v, c0);

    // clear all flags, check readback of flags register
    wr(AW'(NCH), 16'h000F);
    rd(AW'(NCH), v);
    chk("R6 flag register readback", v, 16'h0);
    chk("R7 all flags cleared", {12'h0, flags}, 16'h0);

    // compare: toggle on ch0, set on ch1
    act_sel = 8'b00_00_11_01;
    c0 = cnt_val + 16'd6;
    wr(AW'(0), c0);
    wr(AW'(1), c0 + 16'd4);
    run_to(c0);
    chk("R8 output unchanged in match cycle", {15'h0, cmp_out[0]}, 16'h0);
    step(1);
    chk("R8 toggle one clock after match", {15'h0, cmp_out[0]}, 16'h1);
    chk("R7 flag set by match", {15'h0, flags[0]}, 16'h1);
    step(3);
    chk("R8 single event while counter held", {15'h0, cmp_out[0]}, 16'h1);
    run_to(c0 + 16'd4);
    step(1);
    chk("R8 set action", {15'h0, cmp_out[1]}, 16'h1);
    // set wins over clear on same edge: write clear in match cycle
    act_sel = 8'b00_00_10_00;
    c1 = cnt_val + 16'd3;
    wr(AW'(1), c1);
    wr(AW'(NCH), 16'h0003);
    chk("R7 flags cleared before match", {12'h0, flags}, 16'h0);
    run_to(c1);
    wr(AW'(NCH), 16'h0002);
    chk("R7 set wins over clear", {15'h0, flags[1]}, 16'h1);
    chk("R8 clear action", {15'h0, cmp_out[1]}, 16'h0);
    chk("R8 no-change action", {15'h0, cmp_out[0]}, 16'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule